// File: doc/BRIEF.md
# Tick-Counted Rising-Edge Delay

This block shifts every rising edge of a pulse input later in time by a fixed number of ticks. A tick is a one-clock enable strobe from an external generator. It runs at the system clock rate or below it. The number of ticks is fixed when the design is built. The time that this delay represents is changed at run time by speeding up or slowing down the tick strobe. For example, 1000 ticks at 1 kHz is exactly one second. The resolution of the delay is one tick period.

Only rising edges are carried through the block. When ticks are slower than the clock, the high time of a pulse cannot be reproduced faithfully. So each delayed edge leaves the block as a single-clock pulse, and any pulse width is added downstream. The output pulse rate follows the input pulse rate: 4 Hz in gives 4 Hz out, each edge shifted by the delay.

Several edges can be waiting at once. A wrapping tick counter stamps each edge, and the stamp is held in a small ordered store. When that store is full, a new edge is lost and a sticky loss flag is raised.

Top module: `edge_tick_delay`

## Requirements
- R1: Reset does the following: drives `edge_out` and `overflow` low, discards every pending edge and clears the tick counter. After reset, no output pulse appears until a new rising edge has been accepted and has aged.
- R2: A rising edge is a clock cycle with `pulse_in` high after a cycle with it low. The level before reset counts as low. Counting from that cycle inclusive, `edge_out` goes high for one clock in the cycle that follows two rising clock edges after the `DELAY_TICKS`-th clock edge with `tick_en` high. With `tick_en` held high, that cycle is `DELAY_TICKS`+1 cycles after the edge cycle.
- R3: Holding `pulse_in` high produces only one delayed pulse. A falling edge of `pulse_in` produces no pulse at all.
- R4: Up to `DEPTH` edges can be pending at the same time. They leave in arrival order, and each one is delayed by the full tick count.
- R5: The tick counter advances only on cycles with `tick_en` high. With no ticks, no pending edge is ever released. The delay measured in clock cycles therefore grows with the spacing of the ticks.
- R6: A rising edge that arrives while `DEPTH` edges are pending, and none is being released in that cycle, is dropped. It then never produces a pulse. `overflow` goes high on the next clock and stays high until reset. The edges already stored are still released.
- R7: Edges that fall due on the same tick are released one per clock, on consecutive cycles, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Pulse signal whose rising edges are delayed |
| tick_en | input | 1 | One-clock tick strobe that clocks the delay |
| edge_out | output | 1 | One-clock pulse for each delayed rising edge |
| overflow | output | 1 | Sticky flag: an edge was lost because the store was full |

## Verification
The hardest situation to reach is a full store: edges that share one stamp, one arriving while the store is full, and one being released in the same cycle. The stimulus reaches it by stopping the tick strobe and sending rising edges two clocks apart until more than `DEPTH` are waiting. It then restarts the ticks, so that the whole backlog falls due on a single tick and must drain on consecutive clocks. A behavioural model based on a queue follows every cycle. Separate phases use slow ticks, ticks that stop for a long time, and a reset while edges are pending.

// File: rtl/edly_pkg.sv
package edly_pkg;
   // Advances a circular index and wraps it back to zero after depth-1.
   function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
      return (idx + 1 >= depth) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/edly_rise_det.sv
module edly_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign rise = level & ~level_q;

   // R3: a rising edge can never be reported on two cycles in a row
   a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/edly_tick_ctr.sv
module edly_tick_ctr #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic [CNT_W-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       now <= '0;
      else if (tick_en) now <= now + 1'b1;
   end

   // R5: time stands still without a tick
   a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(now));
endmodule

// File: rtl/edly_stamp_fifo.sv
module edly_stamp_fifo #(
   parameter int unsigned WIDTH = 10,
   parameter int unsigned DEPTH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [WIDTH-1:0]         din,
   input  logic                     pop,
   output logic [WIDTH-1:0]         head,
   output logic                     empty,
   output logic                     full,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned FILL_W = $clog2(DEPTH+1);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [WIDTH-1:0] slot [DEPTH];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot[gi] <= '0;
            else if (push && wr_ptr == PTR_W'(gi))
               slot[gi] <= din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= PTR_W'(edly_pkg::wrap_inc(int'(wr_ptr), DEPTH));
         if (pop)  rd_ptr <= PTR_W'(edly_pkg::wrap_inc(int'(rd_ptr), DEPTH));
         if (push && !pop)      fill <= fill + 1'b1;
         else if (pop && !push) fill <= fill - 1'b1;
      end
   end

   assign head  = slot[rd_ptr];
   assign empty = (fill == '0);
   assign full  = (fill == FILL_W'(DEPTH));

   // R4: occupancy never goes past the configured depth
   a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(DEPTH));
   // R6: a full store accepts no write unless one leaves in the same cycle
   a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push) |-> pop);
   // R1: nothing is ever read from an empty store
   a_r1_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/edge_tick_delay.sv
module edge_tick_delay #(
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned DELAY_TICKS = 1000,
   parameter int unsigned DEPTH       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_in,
   input  logic tick_en,
   output logic edge_out,
   output logic overflow
);
   localparam int unsigned FILL_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] DLY = CNT_W'(DELAY_TICKS);

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("edge_tick_delay: CNT_W must lie in 2..31");
      end
      if (DELAY_TICKS < 1) begin : g_bad_delay
         $error("edge_tick_delay: DELAY_TICKS must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("edge_tick_delay: DEPTH must be at least 2");
      end
      if (DELAY_TICKS + DEPTH >= (64'd1 << CNT_W)) begin : g_bad_range
         $error("edge_tick_delay: DELAY_TICKS + DEPTH must fit the tick counter");
      end
   endgenerate

   logic             rise;
   logic [CNT_W-1:0] now, head, age;
   logic             empty, full, due, accept, drop;
   logic [FILL_W-1:0] fill;

   edly_rise_det u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pulse_in),
      .rise  (rise)
   );

   edly_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .now     (now)
   );

   // Modular age is unambiguous because no stamp gets older than DELAY_TICKS+DEPTH.
   assign age    = now - head;
   assign due    = !empty && (age >= DLY);
   assign accept = rise && (!full || due);
   assign drop   = rise && full && !due;

   edly_stamp_fifo #(.WIDTH(CNT_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   (now),
      .pop   (due),
      .head  (head),
      .empty (empty),
      .full  (full),
      .fill  (fill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_out <= 1'b0;
         overflow <= 1'b0;
      end else begin
         edge_out <= due;
         overflow <= overflow | drop;
      end
   end

   // R6: once set, the loss flag stays set
   a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R6: a dropped edge leaves the occupancy unchanged
   a_r6_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (fill == $past(fill)) && overflow);
   // R2: every released stamp becomes exactly one output pulse
   a_r2_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      due |=> edge_out);
   // R2: no output pulse without a release in the cycle before
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !due |=> !edge_out);
endmodule

// File: tb/tb_edge_tick_delay.sv
module tb_edge_tick_delay;
   localparam int CNT_W = 4;
   localparam int DELAY = 5;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_in = 1'b0;
   logic tick_en = 1'b0;
   logic edge_out, overflow;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";
   int pulses = 0;

   always #5 clk = ~clk;

   edge_tick_delay #(.CNT_W(CNT_W), .DELAY_TICKS(DELAY), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .tick_en(tick_en),
      .edge_out(edge_out), .overflow(overflow)
   );

   // Behavioural reference: unbounded tick count and a queue of stamps.
   int  m_ticks = 0;
   int  m_q[$];
   bit  m_prev = 1'b0;
   bit  m_out = 1'b0;
   bit  m_ovf = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ticks = 0; m_q.delete(); m_prev = 1'b0; m_out = 1'b0; m_ovf = 1'b0;
      end else begin
         bit r, p;
         r = pulse_in && !m_prev;
         p = (m_q.size() > 0) && (m_ticks - m_q[0] >= DELAY);
         if (p) void'(m_q.pop_front());
         if (r) begin
            if (m_q.size() < DEPTH) m_q.push_back(m_ticks);
            else m_ovf = 1'b1;
         end
         m_out = p;
         m_prev = pulse_in;
         if (tick_en) m_ticks++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(edge_out === m_out, {cur_req, " edge_out"}, int'(edge_out), int'(m_out));
         chk(overflow === m_ovf, {cur_req, " overflow"}, int'(overflow), int'(m_ovf));
      end
      if (rst_n && edge_out === 1'b1) pulses++;
   end

   task automatic step(input bit p, input bit t);
      @(negedge clk);
      pulse_in = p;
      tick_en = t;
   endtask

   task automatic idle(input int n, input bit t);
      for (int i = 0; i < n; i++) step(1'b0, t);
   endtask

   initial begin
      int first, base;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(edge_out === 1'b0, "R1 reset edge_out", int'(edge_out), 0);
      chk(overflow === 1'b0, "R1 reset overflow", int'(overflow), 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // R2: single edge, tick every cycle
      cur_req = "R2";
      idle(3, 1'b1);
      step(1'b1, 1'b1);
      first = 0;
      for (int i = 1; i <= 12; i++) begin
         step(1'b0, 1'b1);
         if (edge_out && first == 0) first = i;
      end
      chk(first == DELAY + 1, "R2 latency in cycles", first, DELAY + 1);

      // R3: long high level and falling edge
      cur_req = "R3";
      base = pulses;
      for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
      idle(15, 1'b1);
      chk(pulses - base == 1, "R3 one pulse per high level", pulses - base, 1);

      // R5: slow ticks, then ticks stopped
      cur_req = "R5";
      base = pulses;
      step(1'b1, 1'b0);
      for (int i = 0; i < 40; i++) step(1'b0, (i % 3) == 0);
      chk(pulses - base == 1, "R5 slow tick pulse", pulses - base, 1);
      base = pulses;
      step(1'b1, 1'b1);
      idle(30, 1'b0);
      chk(pulses - base == 0, "R5 no release without ticks", pulses - base, 0);
      idle(12, 1'b1);
      chk(pulses - base == 1, "R5 release once ticks resume", pulses - base, 1);

      // R4: several edges in flight with varied spacing
      cur_req = "R4";
      base = pulses;
      step(1'b1, 1'b1); step(1'b0, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b1);
      step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b1);
      idle(20, 1'b1);
      chk(pulses - base == 3, "R4 all in-flight edges emitted", pulses - base, 3);

      // R7 and R6: backlog with stopped ticks, overflow, then simultaneous due
      cur_req = "R6";
      base = pulses;
      for (int i = 0; i < DEPTH + 2; i++) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
      end
      step(1'b0, 1'b0);
      chk(overflow === 1'b1, "R6 overflow set", int'(overflow), 1);
      cur_req = "R7";
      idle(DELAY, 1'b1);
      first = 0;
      for (int i = 0; i < DEPTH + 4; i++) begin
         step(1'b0, 1'b0);
         if (edge_out) first++;
      end
      chk(pulses - base == DEPTH, "R6 only stored edges emitted", pulses - base, DEPTH);
      chk(first == DEPTH, "R7 backlog drains back to back", first, DEPTH);
      chk(overflow === 1'b1, "R6 overflow sticky", int'(overflow), 1);

      // R1: reset while edges are pending
      cur_req = "R1";
      step(1'b1, 1'b1); step(1'b0, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(overflow === 1'b0, "R1 reset clears overflow", int'(overflow), 0);
      rst_n = 1'b1;
      base = pulses;
      idle(20, 1'b1);
      chk(pulses - base == 0, "R1 pending edges discarded", pulses - base, 0);

      cmp_en = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule